// File: doc/BRIEF.md
# Context-Configured Word Processing Cell

This block is one word-level processing cell of a coarse-grain configurable array. Every operation is set by a 32-bit configuration word held in the cell's own context register. Each word selects the two ALU operands, the function, the post-shift and the register-file entries that take the result. The surrounding array routes neighbour, row/column peer, lane, bus and cross-quadrant operands in as one flat vector. The cell returns its 32-bit registered result and a sign flag.

A controller loads a configuration word with `ctx_load` and runs it with `exec_en`. Loading and executing may overlap: an execute cycle always uses the word already held, so the next word can be loaded while the current one runs. The datapath has a 16-bit operand path, a 16x12 multiplier and a 28-bit adder that accumulates onto the output register. This gives single-cycle multiply-accumulate. A logical shifter sits in front of the output register, and a four-entry register file, a sign flag and a feedback register hold local state.

Configuration word layout (bit 31 first): function code [31:27], operand-A select [26:23], operand-B select [22:20], register write mask [19:16], shift direction [15] (1 = left, 0 = right), shift amount [14:12], constant/sub-code [11:0].

Top module: `rc_cell`

## Requirements
- R1: After reset `out_q` is 0, `flag_q` is 0, all four register-file entries and the feedback register are 0, and the held configuration word is 0.
- R2: `ctx_load` high captures `ctx_in` at the clock edge. An execute cycle always uses the word held before that edge, even when a new word is loaded in the same cycle.
- R3: Operand A select codes: 0 north, 1 east, 2 south, 3 west, 4-5 row peers, 6-7 column peers, 8 lane, 9 bus, 10 feedback register, 11 cross-quadrant, 12-15 register entries 0-3. Flat vector slots: north 0, east 1, south 2, west 3, peers 4-7, lane 8, bus 9, cross-quadrant 10; slot i occupies bits [16i+15:16i].
- R4: Operand B select codes: 0-3 register entries 0-3, 4 bus, 5 north, 6 east, 7 south.
- R5: Function codes 0 pass A, 1 A+B, 2 A-B, 3 |A-B| use sign-extended 16-bit operands. The 28-bit result is sign-extended to 32 bits, so carries beyond 16 bits are kept.
- R6: Function codes 4 AND, 5 OR, 6 XOR, 7 NOT A give a 16-bit result that is sign-extended to 32 bits.
- R7: Function codes 8 A+K, 9 A-K and 10 A*K use the 12-bit constant K, sign-extended.
- R8: Code 11 (acc + A*K) and code 13 (acc + A*B[11:0], B low 12 bits signed) add the product to the low 28 bits of the previous `out_q` as signed. The sum wraps at 28 bits and is sign-extended to 32. Code 12 is A*B[11:0].
- R9: The 32-bit result is logically shifted by the 3-bit amount field in the direction given by bit 15. An amount of 0 leaves it unshifted.
- R10: For functions that use no constant (all but 8-11), constant bit 4 set replaces the shift amount with constant bits [3:0] (0-15). For codes 8-11 bit 4 is part of K and the amount field is used.
- R11: Code 14 takes a sub-code from constant bits [11:8]: 0 signed minimum of A and B, 1 signed maximum, 2 pass B, 3 negate A; other sub-codes and function codes 15-31 give 0.
- R12: Each set bit i of the write mask writes the low 16 bits of the shifted result into register entry i. Entries whose mask bit is clear keep their value.
- R13: Every execute cycle sets `flag_q` to bit 15 of operand A and loads operand A into the feedback register.
- R14: While `exec_en` is low, `out_q`, `flag_q`, the register file and the feedback register keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_load | input | 1 | Capture `ctx_in` into the context register |
| ctx_in | input | 32 | Configuration word to load |
| exec_en | input | 1 | Execute the held configuration word this cycle |
| opnd_in | input | 176 | Eleven 16-bit external operands, slot i at [16i+15:16i] |
| out_q | output | 32 | Registered shifted result |
| flag_q | output | 1 | Registered sign of operand A |

## Verification
The bench builds the cell with its default parameters: 16-bit operands, 12-bit constant, 28-bit adder, 32-bit output and four register entries. At these widths a product of the largest operands still fits, while repeated accumulation reaches the 28-bit wrap. With a 32-bit output, left shifts of up to 15 carry bits well past the register-file width. Register-file contents and the feedback register are observed at the ports by routing them through operand A in a later pass operation.

// File: rtl/rc_cell_pkg.sv
package rc_cell_pkg;

    localparam int CTX_W = 32;

    typedef enum logic [4:0] {
        FN_PASSA = 5'd0,
        FN_ADD   = 5'd1,
        FN_SUB   = 5'd2,
        FN_ABSD  = 5'd3,
        FN_AND   = 5'd4,
        FN_OR    = 5'd5,
        FN_XOR   = 5'd6,
        FN_NOTA  = 5'd7,
        FN_ADDK  = 5'd8,
        FN_SUBK  = 5'd9,
        FN_MULK  = 5'd10,
        FN_MACK  = 5'd11,
        FN_MULB  = 5'd12,
        FN_MACB  = 5'd13,
        FN_EXT   = 5'd14
    } fn_e;

    typedef struct packed {
        logic [4:0]  fn;
        logic [3:0]  sel_a;
        logic [2:0]  sel_b;
        logic [3:0]  wmask;
        logic        left;
        logic [2:0]  amt;
        logic [11:0] k;
    } ctx_t;

    // operand A source codes
    localparam logic [3:0] SA_LANE = 4'd8;
    localparam logic [3:0] SA_BUS  = 4'd9;
    localparam logic [3:0] SA_FB   = 4'd10;
    localparam logic [3:0] SA_XQ   = 4'd11;

    // external slots
    localparam int SL_LANE = 8;
    localparam int SL_BUS  = 9;
    localparam int SL_XQ   = 10;

    function automatic logic fn_uses_k(input logic [4:0] fn);
        return (fn >= 5'd8) && (fn <= 5'd11);
    endfunction

endpackage

// File: rtl/rc_opsel.sv
module rc_opsel
    import rc_cell_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NEXT = 11,
    parameter int RFN  = 4
) (
    input  logic [NEXT*DW-1:0]      ext_flat,
    input  logic [DW-1:0]           fb,
    input  logic [RFN-1:0][DW-1:0]  rf,
    input  logic [3:0]              sel_a,
    input  logic [2:0]              sel_b,
    output logic [DW-1:0]           opa,
    output logic [DW-1:0]           opb
);
    localparam int NA = 16;
    localparam int NB = 8;

    logic [DW-1:0] ext_a [NEXT];
    logic [DW-1:0] src_a [NA];
    logic [DW-1:0] src_b [NB];

    for (genvar g = 0; g < NEXT; g++) begin : g_unpack
        assign ext_a[g] = ext_flat[g*DW +: DW];
    end

    // neighbours and peers occupy codes 0-7 directly
    for (genvar g = 0; g < 8; g++) begin : g_near
        assign src_a[g] = ext_a[g];
    end
    assign src_a[SA_LANE] = ext_a[SL_LANE];
    assign src_a[SA_BUS]  = ext_a[SL_BUS];
    assign src_a[SA_FB]   = fb;
    assign src_a[SA_XQ]   = ext_a[SL_XQ];

    for (genvar g = 0; g < RFN; g++) begin : g_rf
        assign src_a[12+g] = rf[g];
        assign src_b[g]    = rf[g];
    end
    assign src_b[4] = ext_a[SL_BUS];
    assign src_b[5] = ext_a[0];
    assign src_b[6] = ext_a[1];
    assign src_b[7] = ext_a[2];

    always_comb begin
        opa = src_a[sel_a];
        opb = src_b[sel_b];
    end
endmodule

// File: rtl/rc_alu.sv
module rc_alu
    import rc_cell_pkg::*;
#(
    parameter int DW = 16,
    parameter int KW = 12,
    parameter int AW = 28
) (
    input  logic [4:0]    fn,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [KW-1:0] k,
    input  logic [AW-1:0] acc,
    output logic [AW-1:0] res
);
    logic [AW-1:0] a_x, b_x, k_x, b12_x, diff, prod_k, prod_b;
    logic [3:0]    sub;

    function automatic logic [AW-1:0] sx(input logic [DW-1:0] v);
        return {{(AW-DW){v[DW-1]}}, v};
    endfunction

    always_comb begin
        a_x    = sx(a);
        b_x    = sx(b);
        k_x    = {{(AW-KW){k[KW-1]}}, k};
        b12_x  = {{(AW-KW){b[KW-1]}}, b[KW-1:0]};
        diff   = a_x - b_x;
        prod_k = a_x * k_x;
        prod_b = a_x * b12_x;
        sub    = k[KW-1 -: 4];
        res    = '0;
        case (fn)
            FN_PASSA: res = a_x;
            FN_ADD:   res = a_x + b_x;
            FN_SUB:   res = diff;
            FN_ABSD:  res = diff[AW-1] ? (~diff + 1'b1) : diff;
            FN_AND:   res = sx(a & b);
            FN_OR:    res = sx(a | b);
            FN_XOR:   res = sx(a ^ b);
            FN_NOTA:  res = sx(~a);
            FN_ADDK:  res = a_x + k_x;
            FN_SUBK:  res = a_x - k_x;
            FN_MULK:  res = prod_k;
            FN_MACK:  res = acc + prod_k;
            FN_MULB:  res = prod_b;
            FN_MACB:  res = acc + prod_b;
            FN_EXT: begin
                case (sub)
                    4'd0:    res = ($signed(a) < $signed(b)) ? a_x : b_x;
                    4'd1:    res = ($signed(a) < $signed(b)) ? b_x : a_x;
                    4'd2:    res = b_x;
                    4'd3:    res = '0 - a_x;
                    default: res = '0;
                endcase
            end
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/rc_shift.sv
module rc_shift #(
    parameter int OW = 32,
    parameter int SW = 4
) (
    input  logic [OW-1:0] din,
    input  logic          left,
    input  logic [SW-1:0] amt,
    output logic [OW-1:0] dout
);
    always_comb begin
        if (left) dout = din << amt;
        else      dout = din >> amt;
    end
endmodule

// File: rtl/rc_cell.sv
module rc_cell
    import rc_cell_pkg::*;
#(
    parameter int DW   = 16,
    parameter int KW   = 12,
    parameter int AW   = 28,
    parameter int OW   = 32,
    parameter int RFN  = 4,
    parameter int NEXT = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctx_load,
    input  logic [CTX_W-1:0]     ctx_in,
    input  logic                 exec_en,
    input  logic [NEXT*DW-1:0]   opnd_in,
    output logic [OW-1:0]        out_q,
    output logic                 flag_q
);
    localparam int SW = 4;

    typedef struct packed {
        ctx_t                   ctx;
        logic [OW-1:0]          out;
        logic [RFN-1:0][DW-1:0] rf;
        logic                   flag;
        logic [DW-1:0]          fb;
    } st_t;

    st_t s_d, s_q;

    logic [DW-1:0] opa, opb;
    logic [AW-1:0] alu_res;
    logic [OW-1:0] res_x, shifted;
    logic [SW-1:0] eff_amt;

    rc_opsel #(.DW(DW), .NEXT(NEXT), .RFN(RFN)) u_opsel (
        .ext_flat (opnd_in),
        .fb       (s_q.fb),
        .rf       (s_q.rf),
        .sel_a    (s_q.ctx.sel_a),
        .sel_b    (s_q.ctx.sel_b),
        .opa      (opa),
        .opb      (opb)
    );

    rc_alu #(.DW(DW), .KW(KW), .AW(AW)) u_alu (
        .fn   (s_q.ctx.fn),
        .a    (opa),
        .b    (opb),
        .k    (s_q.ctx.k),
        .acc  (s_q.out[AW-1:0]),
        .res  (alu_res)
    );

    rc_shift #(.OW(OW), .SW(SW)) u_shift (
        .din  (res_x),
        .left (s_q.ctx.left),
        .amt  (eff_amt),
        .dout (shifted)
    );

    always_comb begin
        res_x = {{(OW-AW){alu_res[AW-1]}}, alu_res};
        // extended shift amount rides in the unused constant field
        if (!fn_uses_k(s_q.ctx.fn) && s_q.ctx.k[4])
            eff_amt = s_q.ctx.k[SW-1:0];
        else
            eff_amt = {1'b0, s_q.ctx.amt};

        s_d = s_q;
        if (ctx_load)
            s_d.ctx = ctx_t'(ctx_in);
        if (exec_en) begin
            s_d.out  = shifted;
            s_d.flag = opa[DW-1];
            s_d.fb   = opa;
            for (int i = 0; i < RFN; i++)
                if (s_q.ctx.wmask[i])
                    s_d.rf[i] = shifted[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_q  = s_q.out;
    assign flag_q = s_q.flag;

    AST_CTX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_load |=> s_q.ctx == $past(ctx_in)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> $stable(out_q) && $stable(flag_q) && $stable(s_q.rf) && $stable(s_q.fb)); // R14
    AST_LEFT_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && s_q.ctx.left && eff_amt != '0 |=> out_q[0] == 1'b0); // R9
    AST_RIGHT_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && !s_q.ctx.left && eff_amt != '0 |=> out_q[OW-1] == 1'b0); // R9
    AST_MASK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && s_q.ctx.wmask == '0 |=> $stable(s_q.rf)); // R12
    AST_FLAG_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en |=> flag_q == $past(opa[DW-1])); // R13
endmodule

// File: tb/rc_cell_bench.sv
module rc_cell_bench;
    localparam int DW = 16;
    localparam int NEXT = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctx_load = 1'b0;
    logic [31:0]       ctx_in = '0;
    logic              exec_en = 1'b0;
    logic [NEXT*DW-1:0] opnd_in;
    logic [31:0]       out_q;
    logic              flag_q;

    logic [15:0] ext [NEXT];
    logic [31:0] m_out, m_ctx;
    logic [15:0] m_rf [4];
    logic [15:0] m_fb;
    logic        m_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    always_comb
        for (int i = 0; i < NEXT; i++) opnd_in[i*DW +: DW] = ext[i];

    rc_cell u_rc_cell (
        .clk(clk), .rst_n(rst_n), .ctx_load(ctx_load), .ctx_in(ctx_in),
        .exec_en(exec_en), .opnd_in(opnd_in), .out_q(out_q), .flag_q(flag_q)
    );

    function automatic logic [31:0] mk(input int fn, input int sa, input int sb,
                                       input int we, input int lf, input int am, input int k);
        return {fn[4:0], sa[3:0], sb[2:0], we[3:0], lf[0], am[2:0], k[11:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] src_a(input int s);
        if (s < 10) return ext[s];
        if (s == 10) return m_fb;
        if (s == 11) return ext[10];
        return m_rf[s-12];
    endfunction

    function automatic logic [15:0] src_b(input int s);
        if (s < 4) return m_rf[s];
        if (s == 4) return ext[9];
        return ext[s-5];
    endfunction

    function automatic longint sx28(input logic [27:0] v);
        return longint'({{36{v[27]}}, v});
    endfunction

    task automatic model_exec();
        logic [15:0] a16, b16;
        logic [11:0] k;
        longint a, b, kk, b12, acc, r;
        logic [27:0] r28;
        logic [31:0] v;
        int fn, amt;
        a16 = src_a(int'(m_ctx[26:23]));
        b16 = src_b(int'(m_ctx[22:20]));
        k = m_ctx[11:0];
        fn = int'(m_ctx[31:27]);
        a = longint'($signed(a16)); b = longint'($signed(b16));
        kk = longint'($signed(k)); b12 = longint'($signed(b16[11:0]));
        acc = sx28(m_out[27:0]);
        case (fn)
            0: r = a;  1: r = a + b;  2: r = a - b;
            3: r = (a > b) ? a - b : b - a;
            4: r = longint'($signed(a16 & b16));
            5: r = longint'($signed(a16 | b16));
            6: r = longint'($signed(a16 ^ b16));
            7: r = longint'($signed(~a16));
            8: r = a + kk;  9: r = a - kk;  10: r = a * kk;  11: r = acc + a * kk;
            12: r = a * b12;  13: r = acc + a * b12;
            14: case (k[11:8])
                    4'd0: r = (a < b) ? a : b;
                    4'd1: r = (a < b) ? b : a;
                    4'd2: r = b;
                    4'd3: r = -a;
                    default: r = 0;
                endcase
            default: r = 0;
        endcase
        r28 = r[27:0];
        v = {{4{r28[27]}}, r28};
        amt = (!(fn >= 8 && fn <= 11) && k[4]) ? int'(k[3:0]) : int'(m_ctx[14:12]);
        v = m_ctx[15] ? (v << amt) : (v >> amt);
        m_out = v;
        for (int i = 0; i < 4; i++) if (m_ctx[16+i]) m_rf[i] = v[15:0];
        m_flag = a16[15];
        m_fb = a16;
    endtask

    // one drive cycle; results visible at the following negedge
    task automatic cyc(input bit ld, input logic [31:0] c, input bit ex);
        @(negedge clk);
        ctx_in = c; ctx_load = ld; exec_en = ex;
        if (ex) model_exec();
        if (ld) m_ctx = c;
        @(negedge clk);
        ctx_load = 1'b0; exec_en = 1'b0;
    endtask

    task automatic run(input logic [31:0] c);
        cyc(1'b1, c, 1'b0);
        cyc(1'b0, '0, 1'b1);
    endtask

    task automatic run_chk(input string tag, input logic [31:0] c);
        run(c);
        chk(tag, out_q, m_out);
        chk({tag, " flag"}, {31'b0, flag_q}, {31'b0, m_flag});
    endtask

    task automatic t_reset();
        chk("R1 out", out_q, 32'h0);
        chk("R1 flag", {31'b0, flag_q}, 32'h0);
        for (int i = 0; i < 4; i++) begin
            run(mk(0, 12 + i, 0, 0, 0, 0, 0));
            chk("R1 rf", out_q, 32'h0);
        end
        run(mk(0, 10, 0, 0, 0, 0, 0));
        chk("R1 fb", out_q, 32'h0);
    endtask

    task automatic t_sel_a();
        for (int s = 0; s < 12; s++) if (s != 10) begin
            run(mk(0, s, 0, 0, 0, 0, 0));
            chk("R3 opsel A", out_q, {16'h0, ext[s == 11 ? 10 : s]});
        end
    endtask

    task automatic t_sel_b();
        for (int s = 4; s < 8; s++)
            run_chk("R4 opsel B", mk(14, 0, s, 0, 0, 0, 12'h200));
        run(mk(14, 0, 4, 0, 0, 0, 12'h200));
        chk("R4 bus on B", out_q, {16'h0, ext[9]});
    endtask

    task automatic t_arith();
        ext[0] = 16'h7FFF; ext[1] = 16'h0001;
        run(mk(1, 0, 6, 0, 0, 0, 0));
        chk("R5 add carry", out_q, 32'h0000_8000);
        ext[0] = 16'h8000;
        run(mk(2, 0, 6, 0, 0, 0, 0));
        chk("R5 sub borrow", out_q, 32'hFFFF_7FFF);
        ext[0] = 16'd3; ext[1] = 16'd10;
        run(mk(3, 0, 6, 0, 0, 0, 0));
        chk("R5 absdiff", out_q, 32'd7);
        ext[0] = 16'h8000; ext[1] = 16'h7FFF;
        run(mk(3, 0, 6, 0, 0, 0, 0));
        chk("R5 absdiff wide", out_q, 32'h0000_FFFF);
    endtask

    task automatic t_logic();
        ext[0] = 16'hF0F0; ext[1] = 16'h3C3C;
        for (int f = 4; f < 8; f++) run_chk("R6 logic", mk(f, 0, 6, 0, 0, 0, 0));
        run(mk(7, 0, 6, 0, 0, 0, 0));
        chk("R6 not sext", out_q, 32'h0000_0F0F);
    endtask

    task automatic t_const();
        ext[0] = 16'h7FFF;
        run(mk(10, 0, 0, 0, 0, 0, 12'h800));
        chk("R7 mulk", out_q, 32'hFC00_0800);
        ext[0] = 16'd100;
        run(mk(8, 0, 0, 0, 0, 0, 12'hFFF));
        chk("R7 addk neg", out_q, 32'd99);
        run(mk(9, 0, 0, 0, 0, 0, 12'h7FF));
        chk("R7 subk", out_q, 32'hFFFF_F865);
    endtask

    task automatic t_mac();
        ext[0] = 16'h7FFF;
        run(mk(10, 0, 0, 0, 0, 0, 12'h7FF));
        chk("R8 seed", out_q, 32'h03FF_7801);
        run(mk(11, 0, 0, 0, 0, 0, 12'h7FF));
        chk("R8 mac", out_q, 32'h07FE_F002);
        run(mk(11, 0, 0, 0, 0, 0, 12'h7FF));
        chk("R8 mac wrap", out_q, 32'hFBFE_6803);
        ext[1] = 16'h0FFF;
        run_chk("R8 mulb", mk(12, 0, 6, 0, 0, 0, 0));
        run_chk("R8 macb", mk(13, 0, 6, 0, 0, 0, 0));
        run_chk("R8 macb", mk(13, 0, 6, 0, 0, 0, 0));
    endtask

    task automatic t_shift();
        ext[0] = 16'h8001;
        run(mk(0, 0, 0, 0, 1, 7, 0));
        chk("R9 left7", out_q, 32'hFFC0_0080);
        run(mk(0, 0, 0, 0, 0, 3, 0));
        chk("R9 right3", out_q, 32'h1FFF_F000);
        run(mk(0, 0, 0, 0, 1, 0, 0));
        chk("R9 none", out_q, 32'hFFFF_8001);
    endtask

    task automatic t_ext_shift();
        ext[0] = 16'h0003;
        run(mk(0, 0, 0, 0, 1, 1, 12'h01F));
        chk("R10 left15", out_q, 32'h0001_8000);
        run(mk(0, 0, 0, 0, 0, 0, 12'h01C));
        chk("R10 right12 ", out_q, 32'h0);
        run(mk(8, 0, 0, 0, 1, 1, 12'h01F));
        chk("R10 const op ignores", out_q, 32'h0000_0044);
    endtask

    task automatic t_subop();
        ext[0] = 16'hFFFE; ext[1] = 16'h0005;
        run(mk(14, 0, 6, 0, 0, 0, 12'h000));
        chk("R11 min", out_q, 32'hFFFF_FFFE);
        run(mk(14, 0, 6, 0, 0, 0, 12'h100));
        chk("R11 max", out_q, 32'h5);
        run(mk(14, 0, 6, 0, 0, 0, 12'h300));
        chk("R11 neg", out_q, 32'h2);
        run(mk(14, 0, 6, 0, 0, 0, 12'h900));
        chk("R11 undefined sub", out_q, 32'h0);
        run(mk(20, 0, 6, 0, 0, 0, 0));
        chk("R11 undefined fn", out_q, 32'h0);
    endtask

    task automatic t_rf();
        ext[0] = 16'h1234;
        run(mk(0, 0, 0, 4'b0101, 1, 4, 0));
        ext[0] = 16'hABCD;
        run(mk(0, 0, 0, 4'b0010, 0, 0, 0));
        run(mk(0, 0, 0, 4'b0000, 0, 0, 0));
        run(mk(0, 12, 0, 0, 0, 0, 0)); chk("R12 rf0", out_q, 32'h0000_2340);
        run(mk(0, 13, 0, 0, 0, 0, 0)); chk("R12 rf1", out_q, 32'hFFFF_ABCD);
        run(mk(0, 14, 0, 0, 0, 0, 0)); chk("R12 rf2", out_q, 32'h0000_2340);
        run(mk(0, 15, 0, 0, 0, 0, 0)); chk("R12 rf3 kept", out_q, 32'h0);
        for (int s = 0; s < 4; s++)
            run_chk("R12 rf on B", mk(14, 0, s, 0, 0, 0, 12'h200));
    endtask

    task automatic t_flag_fb();
        ext[2] = 16'h9000;
        run(mk(0, 2, 0, 0, 0, 0, 0));
        chk("R13 flag neg", {31'b0, flag_q}, 32'h1);
        ext[2] = 16'h0001;
        run(mk(0, 10, 0, 0, 0, 0, 0));
        chk("R13 feedback", out_q, 32'hFFFF_9000);
        chk("R13 flag from fb", {31'b0, flag_q}, 32'h1);
        run(mk(0, 2, 0, 0, 0, 0, 0));
        chk("R13 flag pos", {31'b0, flag_q}, 32'h0);
    endtask

    task automatic t_ctx();
        ext[0] = 16'h0011; ext[1] = 16'h0022;
        cyc(1'b1, mk(0, 0, 0, 0, 0, 0, 0), 1'b0);
        cyc(1'b1, mk(0, 1, 0, 0, 0, 0, 0), 1'b1);
        chk("R2 old ctx used", out_q, 32'h11);
        cyc(1'b0, '0, 1'b1);
        chk("R2 new ctx", out_q, 32'h22);
    endtask

    task automatic t_hold();
        logic [31:0] keep;
        keep = out_q;
        ext[1] = 16'h5555;
        cyc(1'b1, mk(0, 1, 0, 4'hF, 0, 0, 0), 1'b0);
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk("R14 out held", out_q, keep);
        run(mk(0, 12, 0, 0, 0, 0, 0));
        chk("R14 rf held", out_q, {16'h0, m_rf[0]});
    endtask

    initial begin
        for (int i = 0; i < NEXT; i++) ext[i] = 16'h1000 + 16'(i * 16'h0111);
        m_out = '0; m_ctx = '0; m_fb = '0; m_flag = 1'b0;
        for (int i = 0; i < 4; i++) m_rf[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sel_a();
        t_sel_b();
        t_arith();
        t_logic();
        t_const();
        t_mac();
        t_shift();
        t_ext_shift();
        t_subop();
        t_rf();
        t_flag_fb();
        t_ctx();
        t_hold();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule